// File: doc/BRIEF.md
# Address Translation Unit with Hardware Page-Table Refill

This block turns 32-bit virtual addresses from one requester into physical addresses. It keeps a small, fully associative cache of page table entries. Every entry may hold any page, so a lookup compares the virtual page number against all entries at once. Pages are 4 KB. The low 12 address bits pass through unchanged, and the upper 20 bits select the page.

When a lookup misses, a hardware walker fetches the page table entry through a simple memory port. The entry sits in a flat, single-level table at `base + 4 * page_number`, and the base comes from a base register that the owner loads. A present entry is installed and the lookup runs again. An absent entry is never installed. The block instead raises a held fault response that names the faulting address.

The block keeps each page's referenced and dirty flags current. If an access would change either flag, the block updates the cached copy and writes the entry back to the table before it accepts the request.

Top module: `addr_xlate`

Entry layout, one 32-bit word per page: bit 0 is present, bit 1 is referenced, bit 2 is dirty, bits 11:3 are reserved (written as zero), and bits 31:12 hold the physical page number.

## Requirements
- R1: The physical address is the physical page number of the entry in bits 31:12, with virtual address bits 11:0 copied unchanged into bits 11:0.
- R2: A lookup that hits and needs no flag change raises `req_ready` in the same cycle as `req_valid`, with `rsp_paddr` valid in that cycle.
- R3: On a miss, the block reads the word at `base + 4*vpn`, installs it if bit 0 is set, and retries. If no flag change is then needed, `req_ready` rises 3 cycles after the request, given a memory that acknowledges one cycle after a request.
- R4: An entry whose bit 0 is clear is not installed. `rsp_fault` and `fault_vaddr` stay steady until `flt_ack`, and a repeated request walks the table again.
- R5: A read access to a page whose referenced bit is 0 sets that bit. The block writes the entry back, with the dirty bit kept, before it accepts the request.
- R6: A write access sets the dirty bit and the referenced bit. The updated entry is written to the table before the request is accepted.
- R7: A hit whose flags are already current causes no memory traffic.
- R8: A one-cycle `flush` pulse invalidates every cached entry, so the next access to any page misses.
- R9: While any cached slot is empty, a refill takes an empty slot. Sixteen distinct pages loaded after a flush therefore all remain cached.
- R10: With all slots full, a refill still installs the new page, and an immediate repeat of that access hits.
- R11: A pulse on `base_we` loads `base_wdata` into the table base register, and walks and writebacks use that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Load strobe for the table base register |
| base_wdata | input | 32 | New table base address |
| flush | input | 1 | Invalidate all cached entries |
| req_valid | input | 1 | Translation request present; held until accepted |
| req_write | input | 1 | The request is a write access |
| req_vaddr | input | 32 | Virtual address |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_paddr | output | 32 | Physical address, valid with `req_ready` when no fault |
| rsp_fault | output | 1 | Page fault response, held until `flt_ack` |
| fault_vaddr | output | 32 | Virtual address that faulted |
| flt_ack | input | 1 | Acknowledge of the fault response |
| mem_rd | output | 1 | Table read request, held until `mem_ack` |
| mem_wr | output | 1 | Table write request, held until `mem_ack` |
| mem_addr | output | 32 | Table word address |
| mem_wdata | output | 32 | Entry to write |
| mem_rdata | input | 32 | Entry read, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion |

## Verification
Each result has a fixed due cycle, counted from the request cycle with a memory that answers one cycle after each request:
- A clean hit is due in cycle 0.
- A hit that needs a writeback is due 3 cycles later.
- A refill with current flags is due 3 cycles later, and a refill that also needs a writeback is due 6 cycles later.
- A fault appears 3 cycles after the request.

The bench drives inputs at the falling edge and reads outputs just after it. It counts the falling edges until acceptance and compares that count with the exact figure above. It also checks the modelled table contents and the number of memory transactions after each access.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 32;
  localparam int OFS_W = 12;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [OFS_W-4:0] rsvd;
    logic             dirty;
    logic             refd;
    logic             present;
  } pte_t;

  typedef enum logic [1:0] {W_IDLE, W_READ, W_WBACK, W_FAULT} wstate_t;

  // word address of the entry for one page in the flat table
  function automatic logic [VA_W-1:0] pte_loc(logic [VA_W-1:0] base,
                                              logic [VPN_W-1:0] vpn);
    return base + VA_W'({vpn, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] pa_of(logic [PPN_W-1:0] ppn,
                                            logic [VA_W-1:0] va);
    return {ppn, va[OFS_W-1:0]};
  endfunction

  // entry image after an access marks it
  function automatic pte_t mark_pte(logic [PPN_W-1:0] ppn, logic dirty_now,
                                    logic is_write);
    pte_t p;
    p.ppn     = ppn;
    p.rsvd    = '0;
    p.dirty   = dirty_now | is_write;
    p.refd    = 1'b1;
    p.present = 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/xl_victim.sv
module xl_victim #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] valid_vec,
  output logic [IDX_W-1:0] vic_idx
);
  logic [IDX_W-1:0] rr_q;
  logic             any_free;
  logic [IDX_W-1:0] free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_q + 1'b1;
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign vic_idx = any_free ? free_idx : rr_q;

  // R9: an empty slot is always preferred
  p_vic_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != {N_ENT{1'b1}}) |-> !valid_vec[vic_idx]);
endmodule

// File: rtl/xl_cam.sv
module xl_cam
  import xl_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_ref,
  output logic             hit_dirty,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [VPN_W-1:0] ins_vpn,
  input  pte_t             ins_pte,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_dirty,
  output logic [N_ENT-1:0] valid_vec
);
  logic [VPN_W-1:0] tag_q   [N_ENT];
  logic [PPN_W-1:0] ppn_q   [N_ENT];
  logic [N_ENT-1:0] ref_q;
  logic [N_ENT-1:0] dirty_q;
  logic [N_ENT-1:0] match_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tag_q[g]     <= '0;
        ppn_q[g]     <= '0;
        ref_q[g]     <= 1'b0;
        dirty_q[g]   <= 1'b0;
      end else if (flush) begin
        valid_vec[g] <= 1'b0;
      end else if (ins_en && ins_idx == IDX_W'(g)) begin
        valid_vec[g] <= 1'b1;
        tag_q[g]     <= ins_vpn;
        ppn_q[g]     <= ins_pte.ppn;
        ref_q[g]     <= ins_pte.refd;
        dirty_q[g]   <= ins_pte.dirty;
      end else if (upd_en && upd_idx == IDX_W'(g)) begin
        ref_q[g]     <= 1'b1;
        dirty_q[g]   <= upd_dirty;
      end
    end
    assign match_vec[g] = valid_vec[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (match_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit       = |match_vec;
  assign hit_ppn   = ppn_q[hit_idx];
  assign hit_ref   = ref_q[hit_idx];
  assign hit_dirty = dirty_q[hit_idx];

  // R8: a flush empties every slot by the next cycle
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
  // R10: a page is never cached twice
  p_tag_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/xl_walker.sv
module xl_walker
  import xl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    hit,
  input  logic    hit_ref,
  input  logic    hit_dirty,
  input  logic    rd_present,
  input  logic    mem_ack,
  input  logic    flt_ack,
  output wstate_t st,
  output logic    req_ready,
  output logic    rsp_fault,
  output logic    mem_rd,
  output logic    mem_wr,
  output logic    ins_en,
  output logic    upd_en,
  output logic    wb_start,
  output logic    flt_start
);
  wstate_t nxt;
  logic    need_upd;

  assign need_upd = !hit_ref || (req_write && !hit_dirty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= W_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt       = st;
    req_ready = 1'b0;
    rsp_fault = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    ins_en    = 1'b0;
    upd_en    = 1'b0;
    wb_start  = 1'b0;
    flt_start = 1'b0;
    unique case (st)
      W_IDLE: begin
        if (req_valid) begin
          if (!hit)         nxt = W_READ;
          else if (need_upd) begin
            nxt      = W_WBACK;
            wb_start = 1'b1;
          end else          req_ready = 1'b1;
        end
      end
      W_READ: begin
        mem_rd = 1'b1;
        if (mem_ack) begin
          if (rd_present) begin
            ins_en = 1'b1;
            nxt    = W_IDLE;
          end else begin
            flt_start = 1'b1;
            nxt       = W_FAULT;
          end
        end
      end
      W_WBACK: begin
        mem_wr = 1'b1;
        if (mem_ack) begin
          upd_en = 1'b1;
          nxt    = W_IDLE;
        end
      end
      W_FAULT: begin
        rsp_fault = 1'b1;
        req_ready = flt_ack;
        if (flt_ack) nxt = W_IDLE;
      end
      default: nxt = W_IDLE;
    endcase
  end

  // R3: a memory request stays up until it is answered
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=> (mem_rd || mem_wr));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xl_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  input  logic        flush,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [31:0] fault_vaddr,
  input  logic        flt_ack,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [VA_W-1:0]  base_q;
  logic [VPN_W-1:0] req_vpn;
  logic             hit, hit_ref, hit_dirty;
  logic [IDX_W-1:0] hit_idx, vic_idx, wb_idx;
  logic [PPN_W-1:0] hit_ppn;
  logic [N_ENT-1:0] valid_vec;
  logic             ins_en, upd_en, wb_start, flt_start;
  pte_t             rd_pte, wb_pte;
  wstate_t          st;
  logic             unused_rsvd;

  assign req_vpn     = req_vaddr[VA_W-1:OFS_W];
  assign rd_pte      = pte_t'(mem_rdata);
  assign unused_rsvd = ^rd_pte.rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  // writeback image and slot are frozen on entry to the writeback
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_idx <= '0;
      wb_pte <= '0;
    end else if (wb_start) begin
      wb_idx <= hit_idx;
      wb_pte <= mark_pte(hit_ppn, hit_dirty, req_write);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_vaddr <= '0;
    else if (flt_start) fault_vaddr <= req_vaddr;
  end

  xl_cam #(.N_ENT(N_ENT)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(req_vpn),
    .hit(hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
    .hit_ref(hit_ref), .hit_dirty(hit_dirty),
    .ins_en(ins_en), .ins_idx(vic_idx), .ins_vpn(req_vpn), .ins_pte(rd_pte),
    .upd_en(upd_en), .upd_idx(wb_idx), .upd_dirty(wb_pte.dirty),
    .valid_vec(valid_vec)
  );

  xl_victim #(.N_ENT(N_ENT)) u_vic (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .vic_idx(vic_idx)
  );

  xl_walker u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .hit(hit), .hit_ref(hit_ref), .hit_dirty(hit_dirty),
    .rd_present(rd_pte.present), .mem_ack(mem_ack), .flt_ack(flt_ack),
    .st(st), .req_ready(req_ready), .rsp_fault(rsp_fault),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ins_en(ins_en), .upd_en(upd_en),
    .wb_start(wb_start), .flt_start(flt_start)
  );

  assign mem_addr  = pte_loc(base_q, req_vpn);
  assign mem_wdata = wb_pte;
  assign rsp_paddr = pa_of(hit_ppn, req_vaddr);

  // R4: the fault response and its address hold until acknowledged
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && !flt_ack) |=> (rsp_fault && $stable(fault_vaddr)));
  // R6 (and R5): an accepted translation has current status flags
  p_ack_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !rsp_fault) |-> (hit_ref && (!req_write || hit_dirty)));
  // R3: the table address does not move while a walk waits
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: tb/addr_xlate_bench.sv
module addr_xlate_bench;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0, flush = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic        flt_ack = 1'b0, mem_ack = 1'b0;
  logic [31:0] base_wdata = '0, req_vaddr = '0, mem_rdata = '0;
  logic        req_ready, rsp_fault, mem_rd, mem_wr;
  logic [31:0] rsp_paddr, fault_vaddr, mem_addr, mem_wdata;

  logic [31:0] ptm [256];
  int n_run = 0, n_fail = 0, n_mem = 0, n_badaddr = 0;
  int lat;
  logic [31:0] pa;
  logic flt;

  always #5 clk = ~clk;

  addr_xlate u_addr_xlate (.*);

  // memory model: answers one cycle after a request
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if ((mem_rd || mem_wr) && !mem_ack) begin
      mem_ack <= 1'b1;
      n_mem = n_mem + 1;
      if (mem_addr < BASE || mem_addr >= BASE + 32'd1024 || mem_addr[1:0] != 2'b00) begin
        n_badaddr = n_badaddr + 1;
        mem_rdata <= '0;
      end else if (mem_rd) mem_rdata <= ptm[(mem_addr - BASE) >> 2];
      else ptm[(mem_addr - BASE) >> 2] <= mem_wdata;
    end
  end

  function automatic logic [31:0] mk_pte(logic [19:0] ppn, logic d, logic r, logic p);
    return {ppn, 9'd0, d, r, p};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; lat = falling edges until accept or fault
  task automatic xlate(input logic [31:0] va, input logic wr);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    lat = 0;
    #1;
    while (!req_ready && !rsp_fault && lat < 40) begin
      @(negedge clk); #1; lat++;
    end
    pa = rsp_paddr; flt = rsp_fault;
    if (flt) begin
      flt_ack = 1'b1;
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0; flt_ack = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(!req_ready && !rsp_fault && !mem_rd && !mem_wr, "R4 reset outputs idle",
          {28'd0, req_ready, rsp_fault, mem_rd, mem_wr}, 32'd0);
  endtask

  task automatic t_base_and_miss();
    int m0;
    @(negedge clk); base_we = 1'b1; base_wdata = BASE;
    @(negedge clk); base_we = 1'b0;
    m0 = n_mem;
    xlate(32'h0000_5ABC, 1'b0);
    check(lat == 3 && !flt, "R3 miss refill latency", lat, 3);
    check(pa == 32'h1234_5ABC, "R1 physical address", pa, 32'h1234_5ABC);
    check(n_mem - m0 == 1 && n_badaddr == 0, "R11 one read at base+4*vpn",
          n_mem - m0 + n_badaddr, 1);
  endtask

  task automatic t_hit();
    int m0 = n_mem;
    xlate(32'h0000_5007, 1'b0);
    check(lat == 0, "R2 same-cycle hit", lat, 0);
    check(pa == 32'h1234_5007, "R1 offset passes through", pa, 32'h1234_5007);
    check(n_mem == m0, "R7 clean hit no memory traffic", n_mem - m0, 0);
  endtask

  task automatic t_ref();
    xlate(32'h0000_6010, 1'b0);
    check(lat == 6, "R5 refill plus writeback latency", lat, 6);
    check(ptm[6] == mk_pte(20'h80006, 1'b0, 1'b1, 1'b1), "R5 ref set dirty kept",
          ptm[6], mk_pte(20'h80006, 1'b0, 1'b1, 1'b1));
    xlate(32'h0000_6020, 1'b0);
    check(lat == 0, "R5 clean after update", lat, 0);
  endtask

  task automatic t_dirty();
    int m0 = n_mem;
    xlate(32'h0000_6030, 1'b1);
    check(lat == 3 && n_mem - m0 == 1, "R6 write hit writeback latency", lat, 3);
    check(ptm[6] == mk_pte(20'h80006, 1'b1, 1'b1, 1'b1), "R6 dirty in table",
          ptm[6], mk_pte(20'h80006, 1'b1, 1'b1, 1'b1));
    m0 = n_mem;
    xlate(32'h0000_6040, 1'b1);
    check(lat == 0 && n_mem == m0, "R6 second write clean", lat, 0);
  endtask

  task automatic t_fault();
    int m0 = n_mem;
    logic held;
    @(negedge clk);
    req_vaddr = 32'h0000_7123; req_write = 1'b0; req_valid = 1'b1;
    lat = 0; #1;
    while (!rsp_fault && lat < 40) begin
      @(negedge clk); #1; lat++;
    end
    check(lat == 3, "R4 fault latency", lat, 3);
    held = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      if (!rsp_fault || fault_vaddr != 32'h0000_7123 || req_ready) held = 1'b0;
    end
    check(held, "R4 fault held until ack", fault_vaddr, 32'h0000_7123);
    flt_ack = 1'b1; #1;
    check(req_ready, "R4 ack completes request", req_ready, 1);
    @(negedge clk); req_valid = 1'b0; flt_ack = 1'b0; #1;
    check(!rsp_fault, "R4 fault drops after ack", rsp_fault, 0);
    xlate(32'h0000_7123, 1'b0);
    check(flt && lat == 3 && n_mem - m0 == 2, "R4 not installed, walks again",
          n_mem - m0, 2);
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(32'h0000_5ABC, 1'b0);
    check(lat == 3, "R8 miss after flush", lat, 3);
  endtask

  task automatic t_fill();
    int bad = 0;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int v = 16; v < 32; v++) begin
      xlate(32'(v) << 12, 1'b0);
      if (lat != 3) bad++;
    end
    check(bad == 0, "R9 sixteen refills", bad, 0);
    bad = 0;
    for (int v = 16; v < 32; v++) begin
      xlate((32'(v) << 12) | 32'h44, 1'b0);
      if (lat != 0 || pa != ((32'h80000 + 32'(v)) << 12 | 32'h44)) bad++;
    end
    check(bad == 0, "R9 all sixteen retained", bad, 0);
  endtask

  task automatic t_evict();
    xlate(32'h0002_8000, 1'b0);
    check(lat == 3, "R10 refill when full", lat, 3);
    xlate(32'h0002_8FFC, 1'b0);
    check(lat == 0 && pa == 32'h8002_8FFC, "R10 new page hits", pa, 32'h8002_8FFC);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ptm[i] = mk_pte(20'h80000 + 20'(i), 1'b0, 1'b1, 1'b1);
    ptm[5] = mk_pte(20'h12345, 1'b0, 1'b1, 1'b1);
    ptm[6] = mk_pte(20'h80006, 1'b0, 1'b0, 1'b1);
    ptm[7] = mk_pte(20'h80007, 1'b0, 1'b1, 1'b0);
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_base_and_miss();
    t_hit();
    t_ref();
    t_dirty();
    t_fault();
    t_flush();
    t_fill();
    t_evict();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule